// File: doc/BRIEF.md
# In-Flight Fetch Line Store Guard

This block keeps a record of which cache lines the front end has fetched instructions from while those instructions are still in flight. Each fetched instruction group pushes its line address into a small circular queue. Retirement removes the oldest record. Every store address that the back end presents is compared, in the same cycle, against every live record. A match means a store has rewritten code that may already be in the pipeline. The block then raises a one-cycle clear request, drops every record, and counts the event. The surrounding pipeline restarts fetch just after the last retired instruction.

An explicit serialize strobe takes the same clear path without a store hit. This covers writers that use another address alias that the comparator cannot see. Serialize clears are not counted as store-hit events.

Control is a two-state machine. `ST_TRACK` is the normal state: pushes, retires and store comparisons are taken. The transition `TRACK->FLUSH` fires on a store hit or a serialize strobe; at that same edge the queue is emptied. `ST_FLUSH` lasts one cycle, drives the clear request and ignores every input. The transition `FLUSH->TRACK` is unconditional on the next edge.

Top module: `smc_inflight_guard`

## Requirements
- R1: After reset `clear_req` is 0, `clear_count` is 0 and `fetch_ready` is 1.
- R2: An accepted push records the line address of `fetch_addr`, which is the address with the low 6 bits (64-byte line offset) removed. When `store_valid` is high and `store_addr` falls in any recorded line, `clear_req` is high in the following cycle. The offset bits of either address do not matter.
- R3: No clear is raised when the store line matches no record or when `store_valid` is low.
- R4: `clear_req` lasts exactly one cycle, and `fetch_ready` is 0 during it. Pushes offered in that cycle are dropped. After the pulse the queue is empty, `fetch_ready` is 1, and no earlier line matches a store.
- R5: A retire removes the oldest record. A retired line no longer matches, but younger lines still do. A retire on an empty queue has no effect.
- R6: The queue holds 16 records. `fetch_ready` is 0 while it is full, and a push offered while full is not recorded.
- R7: When a store hit coincides with a retire or a push, the flush takes priority. The coinciding push is not recorded.
- R8: `clear_count` rises by exactly one for each store-hit clear and is unchanged by serialize clears.
- R9: A high `serialize` while tracking raises `clear_req` in the next cycle and empties the queue, even when no store hit occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetched instruction group offers its address |
| fetch_addr | input | 32 | Byte address of the fetched group |
| fetch_ready | output | 1 | Push accepted this cycle if `fetch_valid` |
| retire_valid | input | 1 | Oldest in-flight group retires |
| store_valid | input | 1 | Store address phase is present |
| store_addr | input | 32 | Byte address of the store |
| serialize | input | 1 | Force a clear and resynchronisation |
| clear_req | output | 1 | One-cycle pipeline clear request |
| clear_count | output | 16 | Number of store-hit clears raised |

## Verification
Stores are aimed at a recorded line with a different byte offset, at the neighbouring line, and with the strobe low. These cases separate line-granular matching from exact or byte matching, and show that the valid strobe gates the compare. Stores to lines that were retired, or that were dropped by an earlier clear, show whether pops and flushes really invalidate records rather than merely moving pointers. A hit that coincides with a retire and a push shows the flush priority. A hit on a record that was offered while the queue was full tells whether the full stall actually drops the offered push. Serialize without any store shows the second clear path and that it leaves the event count alone.

// File: rtl/smc_pkg.sv
package smc_pkg;

    // Control states of the guard.
    typedef enum logic [0:0] {
        ST_TRACK = 1'b0,   // taking pushes, retires and store probes
        ST_FLUSH = 1'b1    // one-cycle clear pulse, all inputs ignored
    } guard_state_e;

    // Next index in a circular buffer of the given depth.
    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/smc_line_queue.sv
module smc_line_queue #(
    parameter int LINE_W = 26,
    parameter int DEPTH  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_en,
    input  logic [LINE_W-1:0]             push_line,
    input  logic                          pop_req,
    input  logic                          flush,
    output logic [DEPTH-1:0][LINE_W-1:0]  lines_o,
    output logic [DEPTH-1:0]              vld_o,
    output logic                          full
);
    import smc_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][LINE_W-1:0] line_q;
    logic [DEPTH-1:0]             vld_q;
    logic [PTR_W-1:0]             head_q;
    logic [PTR_W-1:0]             tail_q;
    logic [CNT_W-1:0]             occ_q;
    logic                         empty;
    logic                         push_do;
    logic                         pop_do;

    assign full    = (occ_q == CNT_W'(DEPTH));
    assign empty   = (occ_q == '0);
    assign push_do = push_en && !full;
    assign pop_do  = pop_req && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            vld_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else if (flush) begin
            vld_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (push_do) begin
                line_q[tail_q] <= push_line;
                vld_q[tail_q]  <= 1'b1;
                tail_q         <= PTR_W'(ring_next(32'(tail_q), DEPTH));
            end
            if (pop_do) begin
                vld_q[head_q] <= 1'b0;
                head_q        <= PTR_W'(ring_next(32'(head_q), DEPTH));
            end
            unique case ({push_do, pop_do})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign lines_o = line_q;
    assign vld_o   = vld_q;

endmodule

// File: rtl/smc_line_cmp.sv
module smc_line_cmp #(
    parameter int LINE_W = 26,
    parameter int DEPTH  = 16
) (
    input  logic [DEPTH-1:0][LINE_W-1:0] lines_i,
    input  logic [DEPTH-1:0]             vld_i,
    input  logic                         probe_valid,
    input  logic [LINE_W-1:0]            probe_line,
    output logic                         hit
);
    logic [DEPTH-1:0] match;

    // One comparator per record, all evaluated in the same cycle.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = vld_i[i] && (lines_i[i] == probe_line);
    end

    assign hit = probe_valid && (|match);

endmodule

// File: rtl/smc_clear_fsm.sv
module smc_clear_fsm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_hit,
    input  logic             serialize,
    output logic             tracking,
    output logic             flush,
    output logic             clear_req,
    output logic [CNT_W-1:0] clear_count
);
    import smc_pkg::*;

    guard_state_e state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             count_inc;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    // Transitions: TRACK->FLUSH on hit or serialize, FLUSH->TRACK always.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK: if (store_hit || serialize) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_TRACK;
            default:  state_d = ST_TRACK;
        endcase
    end

    // Outputs.
    always_comb begin
        tracking  = 1'b0;
        flush     = 1'b0;
        clear_req = 1'b0;
        count_inc = 1'b0;
        unique case (state_q)
            ST_TRACK: begin
                tracking  = 1'b1;
                flush     = store_hit || serialize;
                count_inc = store_hit;
            end
            ST_FLUSH: clear_req = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         count_q <= '0;
        else if (count_inc) count_q <= count_q + 1'b1;
    end

    assign clear_count = count_q;

endmodule

// File: rtl/smc_inflight_guard.sv
module smc_inflight_guard #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int DEPTH      = 16,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    input  logic              retire_valid,
    input  logic              store_valid,
    input  logic [ADDR_W-1:0] store_addr,
    input  logic              serialize,
    output logic              clear_req,
    output logic [CNT_W-1:0]  clear_count
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [LINE_W-1:0]             fetch_line;
    logic [LINE_W-1:0]             store_line;
    logic [DEPTH-1:0][LINE_W-1:0]  lines;
    logic [DEPTH-1:0]              vld;
    logic                          full;
    logic                          hit;
    logic                          tracking;
    logic                          flush;
    logic                          push_en;
    logic                          pop_req;

    assign fetch_line = LINE_W'(fetch_addr >> OFF_W);
    assign store_line = LINE_W'(store_addr >> OFF_W);

    assign fetch_ready = tracking && !full;
    assign push_en     = fetch_valid && fetch_ready && !flush;
    assign pop_req     = retire_valid && tracking;

    smc_line_queue #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_line (fetch_line),
        .pop_req   (pop_req),
        .flush     (flush),
        .lines_o   (lines),
        .vld_o     (vld),
        .full      (full)
    );

    smc_line_cmp #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_cmp (
        .lines_i     (lines),
        .vld_i       (vld),
        .probe_valid (store_valid),
        .probe_line  (store_line),
        .hit         (hit)
    );

    smc_clear_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_hit   (hit),
        .serialize   (serialize),
        .tracking    (tracking),
        .flush       (flush),
        .clear_req   (clear_req),
        .clear_count (clear_count)
    );

endmodule

// File: rtl/smc_guard_chk.sv
module smc_guard_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             serialize,
    input logic             fetch_ready,
    input logic             clear_req,
    input logic [CNT_W-1:0] clear_count
);
    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> !clear_req);

    // R4
    stall_during_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |-> !fetch_ready);

    // R4
    ready_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> fetch_ready);

    // R9
    serialize_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serialize && !clear_req) |=> clear_req);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_count == $past(clear_count)) ||
        (clear_count == CNT_W'($past(clear_count) + 1'b1)));

    // R8
    count_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_count != $past(clear_count)) |-> clear_req);

endmodule

bind smc_inflight_guard smc_guard_chk #(.CNT_W(CNT_W)) u_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .serialize   (serialize),
    .fetch_ready (fetch_ready),
    .clear_req   (clear_req),
    .clear_count (clear_count)
);

// File: tb/smc_inflight_guard_tb.sv
module smc_inflight_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready;
    logic        retire_valid = 1'b0;
    logic        store_valid = 1'b0;
    logic [31:0] store_addr = '0;
    logic        serialize = 1'b0;
    logic        clear_req;
    logic [15:0] clear_count;

    int checks = 0;
    int failures = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smc_inflight_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .retire_valid(retire_valid), .store_valid(store_valid), .store_addr(store_addr),
        .serialize(serialize), .clear_req(clear_req), .clear_count(clear_count)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected count seen with the next pulse.
    task automatic expect_clear(int cnt);
        exp_q.push_back(cnt);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        fetch_valid  = 1'b0;
        retire_valid = 1'b0;
        store_valid  = 1'b0;
        serialize    = 1'b0;
    endtask

    task automatic push(logic [31:0] a);
        fetch_valid = 1'b1; fetch_addr = a; tick();
    endtask

    task automatic retire();
        retire_valid = 1'b1; tick();
    endtask

    task automatic store(logic [31:0] a);
        store_valid = 1'b1; store_addr = a; tick();
    endtask

    task automatic store_none(string req, logic [31:0] a);
        store(a);
        check(req, 32'(clear_req), 32'd0);
    endtask

    // Monitor side: every pulse must match the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && clear_req) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R3 unexpected clear act=1 exp=0 count=%0d", clear_count);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (32'(clear_count) != e) begin
                    failures++;
                    $display("FAIL R8 count at clear act=%0d exp=%0d", clear_count, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 clear_req", 32'(clear_req), 0);
        check("R1 count", 32'(clear_count), 0);
        check("R1 ready", 32'(fetch_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 hit on a recorded line at another byte offset
        push(32'h1000); push(32'h2040); push(32'h3080);
        expect_clear(1);
        store(32'h207C);
        check("R2 clear_req", 32'(clear_req), 1);
        check("R4 ready low in pulse", 32'(fetch_ready), 0);
        tick();
        check("R4 pulse one cycle", 32'(clear_req), 0);
        check("R4 ready after", 32'(fetch_ready), 1);

        // R4 all records dropped, not just the matching one
        store_none("R4 old line 0x1000", 32'h1000);
        store_none("R4 old line 0x3080", 32'h3080);

        // R3 neighbouring line and invalid strobe
        push(32'h5000);
        store_none("R3 next line", 32'h5040);
        store_addr = 32'h5000; tick();
        check("R3 strobe low", 32'(clear_req), 0);
        check("R3 count", 32'(clear_count), 1);

        // R5 in-order retire
        retire();
        store_none("R5 retired line", 32'h5000);
        push(32'h6000); push(32'h7000);
        retire();
        store_none("R5 oldest popped", 32'h6000);
        expect_clear(2);
        store(32'h7010);
        check("R5 younger still hits", 32'(clear_req), 1);
        tick();
        retire();   // empty queue
        push(32'h8000);
        expect_clear(3);
        store(32'h8000);
        check("R5 empty retire ignored", 32'(clear_req), 1);
        tick();

        // R6 capacity and full stall
        for (int i = 0; i < 16; i++) begin
            check("R6 ready before fill", 32'(fetch_ready), 1);
            push(32'h10000 + 32'(i) * 64);
        end
        check("R6 ready low when full", 32'(fetch_ready), 0);
        push(32'h9000);
        retire();
        check("R6 ready after pop", 32'(fetch_ready), 1);
        store_none("R6 push while full dropped", 32'h9000);
        store_none("R5 first of full popped", 32'h10000);
        expect_clear(4);
        store(32'h10000 + 15 * 64);
        check("R6 last entry hits", 32'(clear_req), 1);
        tick();

        // R7 flush beats coinciding retire and push
        push(32'hA000); push(32'hB000);
        store_valid = 1'b1; store_addr = 32'hA000;
        retire_valid = 1'b1;
        fetch_valid = 1'b1; fetch_addr = 32'hC000;
        expect_clear(5);
        tick();
        check("R7 clear", 32'(clear_req), 1);
        tick();
        store_none("R7 younger flushed", 32'hB000);
        store_none("R7 coinciding push dropped", 32'hC000);

        // R9 serialize without a hit; R8 count unchanged
        push(32'hD000);
        serialize = 1'b1;
        expect_clear(5);
        tick();
        check("R9 clear_req", 32'(clear_req), 1);
        check("R8 serialize not counted", 32'(clear_count), 5);
        tick();
        store_none("R9 queue emptied", 32'hD000);

        // R4 push offered during pulse is dropped
        push(32'hE000);
        expect_clear(6);
        store(32'hE020);
        fetch_valid = 1'b1; fetch_addr = 32'hF000;
        tick();
        store_none("R4 push in pulse dropped", 32'hF000);

        check("R8 final count", 32'(clear_count), 6);
        check("R2 all expected clears seen", 32'(exp_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule